// File: doc/BRIEF.md
# Port Mode and Data-Memory Select Unit

This unit sits on the register bus of an 8-bit microcontroller. It holds the two write-only configuration registers for the external-memory port: one for ports 0 and 1, one for port 3. It decides how a CPU register access to port 0 or port 1 behaves once part or all of that port has been handed over to address or address/data duty. It also exports the stack-location choice to the rest of the core.

The unit owns the output pin that can act as an active-low data-memory select. A decoded instruction-class strobe from the execution unit tells it when an external data load or a stack operation is in progress. A small state machine turns that strobe into a registered select level. The machine has three states. `DM_IDLE` means no external data access. `DM_DATA` means an external data load is under way. `DM_STACK` means a stack operation is going to an external stack. The transitions are evaluated every clock from the strobe:
- An external-data class goes to `DM_DATA` from any state.
- A stack class goes to `DM_STACK` when the stack is external, and to `DM_IDLE` when it is internal.
- Any other class returns to `DM_IDLE`.

Top module: `pm_port_mode_unit`

## Requirements
- R1: After reset both mode registers are zero. Every port data latch reads 0x00, the pin output is 0, the port 0 address mask is 0x00, and both the port 1 address/data flag and the stack-internal flag are 0.
- R2: The port 0/1 mode register is written at register address 0xF8 and the port 3 mode register at 0xF7. A read at either address returns 0xFF.
- R3: Port 0/1 mode bits 1:0 encode port 0. 00 is plain I/O (mask 0x00), 01 puts the low nibble on address (mask 0x0F), and 1x puts all eight bits on address (mask 0xFF). Bit 3 set puts port 1 on address/data. Bit 2 set means the stack is internal.
- R4: With port 1 on address/data, a read at port 1 (0x01) returns 0xFF and a write there leaves its latch unchanged.
- R5: With port 0 fully on address, a read at port 0 (0x00) returns 0xFF and a write leaves its latch unchanged.
- R6: With only the low nibble of port 0 on address, a read returns the upper latch nibble in bits 7:4 with bits 3:0 forced to 1. A write updates bits 7:4 only.
- R7: A port in plain I/O mode reads back its whole latch and takes a whole-byte write. Port 3 (0x03) is always plain.
- R8: Port 3 mode bits 4:3 pick the pin function. 00 gives port 3 latch bit 4, 01 or 10 gives the data-memory select, and 11 gives the handshake input.
- R9: With the select enabled, the pin is low from one clock after an external-data class (code 01) appears until one clock after it goes away.
- R10: A stack class (code 10) drives the select low one clock later only when bit 2 of the port 0/1 mode register is 0. With bit 2 set, the select stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address for read and write |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the current address |
| xclass_i | input | 2 | Instruction class: 00 none, 01 external data load, 10 stack op, 11 none |
| hs_p34_i | input | 1 | Level from handshake logic for the pin's handshake mode |
| p34_o | output | 1 | Shared port 3 pin output |
| p0_q_o | output | 8 | Port 0 output latch |
| p1_q_o | output | 8 | Port 1 output latch |
| p3_q_o | output | 8 | Port 3 output latch |
| p0_addr_mask_o | output | 8 | Port 0 bits handed to address use |
| p1_addr_data_o | output | 1 | Port 1 is on address/data |
| stack_int_o | output | 1 | Stack is in the internal register file |

## Verification
If a mode register held a wrong value, it would show in the same cycle on the mask, address/data and stack flags, and on the read-back of ports 0 and 1. That is why the bench walks all sixteen low-field codes and reads both ports under each one. A wrong state in the select machine shows on the pin one clock after the strobe changes. The bench samples the pin in that cycle and again while the strobe is held. Latch corruption caused by a write that should have been blocked is hidden while the port is on address duty. It is caught by returning the port to I/O and reading the latch back.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        XC_NONE    = 2'b00,
        XC_EXTDATA = 2'b01,
        XC_STACK   = 2'b10,
        XC_RSVD    = 2'b11
    } xclass_e;

    typedef enum logic [1:0] {
        DM_IDLE  = 2'b00,
        DM_DATA  = 2'b01,
        DM_STACK = 2'b10
    } dm_state_e;

    typedef enum logic [1:0] {
        P34_PLAIN = 2'b00,
        P34_DM_A  = 2'b01,
        P34_DM_B  = 2'b10,
        P34_HS    = 2'b11
    } p34_fn_e;

    typedef enum logic [1:0] {
        P0_IO     = 2'b00,
        P0_LOWNIB = 2'b01,
        P0_FULL   = 2'b10,
        P0_FULL_X = 2'b11
    } p0_fn_e;

    localparam int P01_P0_LSB   = 0;
    localparam int P01_STACK    = 2;
    localparam int P01_P1AD     = 3;
    localparam int P3_P34_LSB   = 3;
    localparam int P34_DATA_BIT = 4;

endpackage

// File: rtl/pm_mode_regs.sv
module pm_mode_regs #(
    parameter int          DW        = 8,
    parameter int          AW        = 8,
    parameter logic [7:0]  P01M_ADDR = 8'hF8,
    parameter logic [7:0]  P3M_ADDR  = 8'hF7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] p01m_o,
    output logic [DW-1:0] p3m_o,
    output logic          hit_o
);
    localparam logic [AW-1:0] A01 = AW'(P01M_ADDR);
    localparam logic [AW-1:0] A3  = AW'(P3M_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p01m_o <= '0;
            p3m_o  <= '0;
        end else if (wr_i) begin
            if (addr_i == A01) p01m_o <= wdata_i;
            if (addr_i == A3)  p3m_o  <= wdata_i;
        end
    end

    assign hit_o = (addr_i == A01) || (addr_i == A3);
endmodule

// File: rtl/pm_port_file.sv
module pm_port_file
    import pm_pkg::*;
#(
    parameter int          DW      = 8,
    parameter int          AW      = 8,
    parameter logic [7:0]  P0_ADDR = 8'h00,
    parameter logic [7:0]  P1_ADDR = 8'h01,
    parameter logic [7:0]  P3_ADDR = 8'h03
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [1:0]    p0_fn_i,
    input  logic          p1_ad_i,
    output logic [DW-1:0] rdata_o,
    output logic [DW-1:0] p0_q_o,
    output logic [DW-1:0] p1_q_o,
    output logic [DW-1:0] p3_q_o,
    output logic [DW-1:0] p0_mask_o
);
    localparam int NW  = DW / 2;
    localparam int NIB = 2;
    localparam logic [AW-1:0] A0 = AW'(P0_ADDR);
    localparam logic [AW-1:0] A1 = AW'(P1_ADDR);
    localparam logic [AW-1:0] A3 = AW'(P3_ADDR);

    p0_fn_e p0_fn;
    logic [NIB-1:0] nib_addr;

    assign p0_fn = p0_fn_e'(p0_fn_i);

    always_comb begin
        unique case (p0_fn)
            P0_IO:     nib_addr = 2'b00;
            P0_LOWNIB: nib_addr = 2'b01;
            P0_FULL,
            P0_FULL_X: nib_addr = 2'b11;
            default:   nib_addr = 2'b11;
        endcase
    end

    for (genvar n = 0; n < NIB; n++) begin : g_p0nib
        assign p0_mask_o[n*NW +: NW] = {NW{nib_addr[n]}};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                p0_q_o[n*NW +: NW] <= '0;
            else if (wr_i && addr_i == A0 && !nib_addr[n])
                p0_q_o[n*NW +: NW] <= wdata_i[n*NW +: NW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p1_q_o <= '0;
            p3_q_o <= '0;
        end else if (wr_i) begin
            if (addr_i == A1 && !p1_ad_i) p1_q_o <= wdata_i;
            if (addr_i == A3)             p3_q_o <= wdata_i;
        end
    end

    always_comb begin
        rdata_o = '1;
        if (addr_i == A0)
            rdata_o = p0_q_o | p0_mask_o;
        else if (addr_i == A1)
            rdata_o = p1_ad_i ? '1 : p1_q_o;
        else if (addr_i == A3)
            rdata_o = p3_q_o;
    end
endmodule

// File: rtl/pm_dm_fsm.sv
module pm_dm_fsm
    import pm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] xclass_i,
    input  logic       stack_int_i,
    output logic       dm_n_o
);
    dm_state_e state_q, state_d;
    xclass_e   xc;

    assign xc = xclass_e'(xclass_i);

    always_comb begin
        unique case (xc)
            XC_EXTDATA: state_d = DM_DATA;
            XC_STACK:   state_d = stack_int_i ? DM_IDLE : DM_STACK;
            XC_NONE,
            XC_RSVD:    state_d = DM_IDLE;
            default:    state_d = DM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            DM_IDLE:  dm_n_o = 1'b1;
            DM_DATA:  dm_n_o = 1'b0;
            DM_STACK: dm_n_o = 1'b0;
            default:  dm_n_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/pm_port_mode_unit.sv
module pm_port_mode_unit
    import pm_pkg::*;
#(
    parameter int          DW        = 8,
    parameter int          AW        = 8,
    parameter logic [7:0]  P01M_ADDR = 8'hF8,
    parameter logic [7:0]  P3M_ADDR  = 8'hF7,
    parameter logic [7:0]  P0_ADDR   = 8'h00,
    parameter logic [7:0]  P1_ADDR   = 8'h01,
    parameter logic [7:0]  P3_ADDR   = 8'h03
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_i,
    input  logic [AW-1:0] reg_addr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    input  logic [1:0]    xclass_i,
    input  logic          hs_p34_i,
    output logic          p34_o,
    output logic [DW-1:0] p0_q_o,
    output logic [DW-1:0] p1_q_o,
    output logic [DW-1:0] p3_q_o,
    output logic [DW-1:0] p0_addr_mask_o,
    output logic          p1_addr_data_o,
    output logic          stack_int_o
);
    logic [DW-1:0] p01m_q, p3m_q, port_rdata;
    logic          mode_hit, dm_n;
    p34_fn_e       p34_fn;

    pm_mode_regs #(
        .DW(DW), .AW(AW), .P01M_ADDR(P01M_ADDR), .P3M_ADDR(P3M_ADDR)
    ) u_modes (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .p01m_o(p01m_q), .p3m_o(p3m_q), .hit_o(mode_hit)
    );

    assign stack_int_o    = p01m_q[P01_STACK];
    assign p1_addr_data_o = p01m_q[P01_P1AD];

    pm_port_file #(
        .DW(DW), .AW(AW), .P0_ADDR(P0_ADDR), .P1_ADDR(P1_ADDR), .P3_ADDR(P3_ADDR)
    ) u_ports (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .p0_fn_i(p01m_q[P01_P0_LSB +: 2]),
        .p1_ad_i(p1_addr_data_o), .rdata_o(port_rdata), .p0_q_o(p0_q_o),
        .p1_q_o(p1_q_o), .p3_q_o(p3_q_o), .p0_mask_o(p0_addr_mask_o)
    );

    pm_dm_fsm u_dm (
        .clk(clk), .rst_n(rst_n), .xclass_i(xclass_i),
        .stack_int_i(stack_int_o), .dm_n_o(dm_n)
    );

    assign reg_rdata_o = mode_hit ? '1 : port_rdata;
    assign p34_fn      = p34_fn_e'(p3m_q[P3_P34_LSB +: 2]);

    always_comb begin
        unique case (p34_fn)
            P34_PLAIN: p34_o = p3_q_o[P34_DATA_BIT];
            P34_DM_A,
            P34_DM_B:  p34_o = dm_n;
            P34_HS:    p34_o = hs_p34_i;
            default:   p34_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/pm_port_mode_chk.sv
module pm_port_mode_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr_i,
    input logic [7:0] reg_addr_i,
    input logic [7:0] reg_rdata_o,
    input logic [1:0] xclass_i,
    input logic       p34_o,
    input logic [7:0] p0_q_o,
    input logic [7:0] p1_q_o,
    input logic [7:0] p0_addr_mask_o,
    input logic       p1_addr_data_o,
    input logic       stack_int_o,
    input logic [7:0] p3m_q
);
    logic dm_en, p3m_wr;
    assign dm_en  = (p3m_q[4:3] == 2'b01) || (p3m_q[4:3] == 2'b10);
    assign p3m_wr = reg_wr_i && (reg_addr_i == 8'hF7);

    AST_MODE_RD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == 8'hF8 || reg_addr_i == 8'hF7) |-> reg_rdata_o == 8'hFF); // R2
    AST_P1_AD_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_addr_data_o && reg_addr_i == 8'h01) |-> reg_rdata_o == 8'hFF); // R4
    AST_P1_AD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_addr_data_o && reg_wr_i && reg_addr_i == 8'h01) |=> $stable(p1_q_o)); // R4
    AST_P0_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_addr_mask_o == 8'hFF && reg_wr_i && reg_addr_i == 8'h00) |=> $stable(p0_q_o)); // R5
    AST_P0_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_addr_mask_o == 8'h0F && reg_wr_i && reg_addr_i == 8'h00) |=> $stable(p0_q_o[3:0])); // R6
    AST_DM_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (xclass_i == 2'b01 && dm_en && !p3m_wr) |=> !p34_o); // R9
    AST_DM_STACK_INT: assert property (@(posedge clk) disable iff (!rst_n)
        (xclass_i == 2'b10 && stack_int_o && dm_en && !p3m_wr) |=> p34_o); // R10
endmodule

bind pm_port_mode_unit pm_port_mode_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_rdata_o(reg_rdata_o), .xclass_i(xclass_i), .p34_o(p34_o),
    .p0_q_o(p0_q_o), .p1_q_o(p1_q_o), .p0_addr_mask_o(p0_addr_mask_o),
    .p1_addr_data_o(p1_addr_data_o), .stack_int_o(stack_int_o), .p3m_q(p3m_q)
);

// File: tb/tb_pm_port_mode_unit.sv
module tb_pm_port_mode_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_i = 1'b0;
    logic [7:0] reg_addr_i = 8'h00;
    logic [7:0] reg_wdata_i = 8'h00;
    logic [7:0] reg_rdata_o;
    logic [1:0] xclass_i = 2'b00;
    logic       hs_p34_i = 1'b0;
    logic       p34_o;
    logic [7:0] p0_q_o, p1_q_o, p3_q_o, p0_addr_mask_o;
    logic       p1_addr_data_o, stack_int_o;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    localparam int S_RD = 0, S_PIN = 1, S_MASK = 2, S_P1AD = 3, S_STK = 4;

    always #4 clk = ~clk;

    pm_port_mode_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .xclass_i(xclass_i),
        .hs_p34_i(hs_p34_i), .p34_o(p34_o), .p0_q_o(p0_q_o), .p1_q_o(p1_q_o),
        .p3_q_o(p3_q_o), .p0_addr_mask_o(p0_addr_mask_o),
        .p1_addr_data_o(p1_addr_data_o), .stack_int_o(stack_int_o)
    );

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic chk(input int sel, input logic [7:0] a, input logic [7:0] e, input string tag);
        item_t it;
        reg_addr_i = a;
        it.sel = sel; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic cls(input logic [1:0] c);
        xclass_i = c;
        @(negedge clk);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                logic [7:0] got;
                it = sb.pop_front();
                case (it.sel)
                    S_RD:    got = reg_rdata_o;
                    S_PIN:   got = {7'b0, p34_o};
                    S_MASK:  got = p0_addr_mask_o;
                    S_P1AD:  got = {7'b0, p1_addr_data_o};
                    default: got = {7'b0, stack_int_o};
                endcase
                n_run++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s actual=%02h expected=%02h", it.tag, got, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        while (!done && cycles < 50000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(S_RD, 8'h00, 8'h00, "R1 p0");
        chk(S_RD, 8'h01, 8'h00, "R1 p1");
        chk(S_RD, 8'h03, 8'h00, "R1 p3");
        chk(S_PIN, 8'h00, 8'h00, "R1 pin");
        chk(S_MASK, 8'h00, 8'h00, "R1 mask");
        chk(S_P1AD, 8'h00, 8'h00, "R1 p1ad");
        chk(S_STK, 8'h00, 8'h00, "R1 stack");
        // R2 mode registers read as ones
        wr(8'hF8, 8'h00);
        chk(S_RD, 8'hF8, 8'hFF, "R2 p01m");
        chk(S_RD, 8'hF7, 8'hFF, "R2 p3m");
        // R7 plain I/O
        wr(8'h00, 8'hA5);
        chk(S_RD, 8'h00, 8'hA5, "R7 p0");
        wr(8'h01, 8'h3C);
        chk(S_RD, 8'h01, 8'h3C, "R7 p1");
        // R6 low nibble on address
        wr(8'hF8, 8'h01);
        chk(S_MASK, 8'h00, 8'h0F, "R3 mask low");
        chk(S_RD, 8'h00, 8'hAF, "R6 merged read");
        wr(8'h00, 8'h12);
        chk(S_RD, 8'h00, 8'h1F, "R6 hi nibble write");
        wr(8'hF8, 8'h00);
        chk(S_RD, 8'h00, 8'h15, "R6 lo nibble kept");
        // R5 full address
        wr(8'hF8, 8'h02);
        chk(S_RD, 8'h00, 8'hFF, "R5 read ones");
        wr(8'h00, 8'h77);
        wr(8'hF8, 8'h03);
        chk(S_RD, 8'h00, 8'hFF, "R5 code 11");
        wr(8'hF8, 8'h00);
        chk(S_RD, 8'h00, 8'h15, "R5 write ignored");
        // R4 port 1 address/data
        wr(8'hF8, 8'h08);
        chk(S_RD, 8'h01, 8'hFF, "R4 read ones");
        wr(8'h01, 8'h99);
        wr(8'hF8, 8'h00);
        chk(S_RD, 8'h01, 8'h3C, "R4 write ignored");
        // R3 all sixteen field codes
        for (int m = 0; m < 16; m++) begin
            logic [7:0] em, e0, e1;
            em = m[1] ? 8'hFF : (m[0] ? 8'h0F : 8'h00);
            e0 = m[1] ? 8'hFF : (m[0] ? 8'h1F : 8'h15);
            e1 = m[3] ? 8'hFF : 8'h3C;
            wr(8'hF8, 8'(m));
            chk(S_MASK, 8'h00, em, "R3 mask");
            chk(S_P1AD, 8'h00, {7'b0, m[3]}, "R3 p1ad");
            chk(S_STK, 8'h00, {7'b0, m[2]}, "R3 stack");
            chk(S_RD, 8'h00, e0, "R3 p0 read");
            chk(S_RD, 8'h01, e1, "R3 p1 read");
        end
        // R8 pin function select
        wr(8'hF8, 8'h00);
        wr(8'hF7, 8'h00);
        wr(8'h03, 8'h10);
        chk(S_RD, 8'h03, 8'h10, "R7 p3");
        chk(S_PIN, 8'h00, 8'h01, "R8 plain one");
        wr(8'h03, 8'h00);
        chk(S_PIN, 8'h00, 8'h00, "R8 plain zero");
        wr(8'hF7, 8'h08);
        chk(S_PIN, 8'h00, 8'h01, "R8 dm idle high");
        wr(8'hF7, 8'h18);
        chk(S_PIN, 8'h00, 8'h00, "R8 hs low");
        hs_p34_i = 1'b1;
        chk(S_PIN, 8'h00, 8'h01, "R8 hs high");
        // R9 external data load
        wr(8'hF7, 8'h08);
        cls(2'b01);
        chk(S_PIN, 8'h00, 8'h00, "R9 low");
        chk(S_PIN, 8'h00, 8'h00, "R9 held low");
        cls(2'b00);
        chk(S_PIN, 8'h00, 8'h01, "R9 release");
        wr(8'hF7, 8'h10);
        cls(2'b01);
        chk(S_PIN, 8'h00, 8'h00, "R9 code 10 low");
        cls(2'b00);
        wr(8'hF7, 8'h00);
        cls(2'b01);
        chk(S_PIN, 8'h00, 8'h00, "R8 plain not dm");
        cls(2'b00);
        // R10 stack operations
        wr(8'hF7, 8'h08);
        cls(2'b10);
        chk(S_PIN, 8'h00, 8'h00, "R10 ext stack low");
        cls(2'b00);
        wr(8'hF8, 8'h04);
        cls(2'b10);
        chk(S_PIN, 8'h00, 8'h01, "R10 int stack high");
        cls(2'b00);
        cls(2'b11);
        chk(S_PIN, 8'h00, 8'h01, "R9 reserved high");
        cls(2'b00);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule